// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Link Monitor

This block keeps the reservation that lets a single-core processor do an atomic read-modify-write without locking the bus. A load-linked operation records the word address it read and arms a link flag. A later store-conditional is allowed to write memory only if the link is still armed and the store targets the same word. The monitor answers in the same cycle with a write grant for the memory port and with the 0 or 1 value that goes into the destination register of the store-conditional.

The link is broken by several events between the load-linked and the store-conditional:

- any store-conditional, whether it succeeds or not;
- an ordinary store that hits the linked word;
- a return from exception.

The pipeline provides one strobe per event class together with a word address. The monitor does not hold any memory data. The load-linked data path goes straight to memory.

Top module: `atomic_link_monitor`

## Requirements
- R1: After synchronous active-low reset the link flag is clear, so a store-conditional issued before any load-linked is refused.
- R2: A load-linked arms the link and records its word address; a store-conditional to that same word in a later cycle, with no breaking event in between, is granted.
- R3: The grant is combinational in the cycle the store-conditional strobe is high, and the destination value is XLEN bits wide: 1 (bit 0 set, all other bits zero) when granted, all zeros when refused.
- R4: A store-conditional to a word address other than the linked one is refused even while the link is armed.
- R5: Every store-conditional clears the link whether or not it was granted, so a second store-conditional with no new load-linked is refused.
- R6: An ordinary store to the linked word breaks the link, and the next store-conditional is refused. An ordinary store to any other word leaves the link intact.
- R7: An exception return strobe breaks the link, and the next store-conditional is refused.
- R8: A second load-linked replaces the recorded address. Only the newer address can then be granted.
- R9: A refused store-conditional keeps the grant low, so memory is not written.
- R10: At most one of the four event strobes is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ll_valid | input | 1 | Load-linked issued this cycle |
| ll_addr | input | ADDR_W | Word address of the load-linked |
| sc_valid | input | 1 | Store-conditional issued this cycle |
| sc_addr | input | ADDR_W | Word address of the store-conditional |
| st_valid | input | 1 | Ordinary store issued this cycle |
| st_addr | input | ADDR_W | Word address of the ordinary store |
| eret_valid | input | 1 | Exception return taken this cycle |
| sc_grant | output | 1 | Store-conditional may write memory this cycle |
| sc_rd_value | output | XLEN | Value for the destination register of the store-conditional |

## Verification
The assertions assume the pipeline never raises two event strobes in the same cycle. They check this assumption (R10) and reason about state one cycle after each event.

The randomized stimulus draws exactly one operation, or an idle cycle, per clock. It uses a four-word address pool, so that matches, mismatches, and store hits on the linked word all happen often. A reference model in the bench tracks the flag and the address from the requirements alone. It predicts the grant and the destination value for every store-conditional.

// File: rtl/atomic_link_pkg.sv
// Package: shared operation type for the link monitor.
// Assumes the pipeline presents at most one event per cycle.
package atomic_link_pkg;
    typedef enum logic [2:0] {
        LOP_IDLE = 3'd0,
        LOP_LOAD = 3'd1,
        LOP_COND = 3'd2,
        LOP_STORE = 3'd3,
        LOP_ERET = 3'd4
    } link_op_e;
endpackage

// File: rtl/link_op_decode.sv
// Module: turns the four event strobes into one operation code.
// Assumes the strobes are mutually exclusive; the fixed priority only
// matters if that assumption is broken.
module link_op_decode
    import atomic_link_pkg::*;
(
    input  logic     ll_valid,
    input  logic     sc_valid,
    input  logic     st_valid,
    input  logic     eret_valid,
    output link_op_e op
);
    // Purpose: pick the operation for this cycle.
    always_comb begin
        op = LOP_IDLE;
        if (eret_valid)
            op = LOP_ERET;
        else if (sc_valid)
            op = LOP_COND;
        else if (ll_valid)
            op = LOP_LOAD;
        else if (st_valid)
            op = LOP_STORE;
    end
endmodule

// File: rtl/link_addr_match.sv
// Module: compares a probe word address against the linked word address.
// GRAIN_LSB widens the reservation granule by ignoring low address bits.
// Assumes both addresses are word addresses of the same width.
module link_addr_match #(
    parameter int ADDR_W    = 30,
    parameter int GRAIN_LSB = 0
) (
    input  logic [ADDR_W-1:0] link_addr,
    input  logic [ADDR_W-1:0] probe_addr,
    output logic              hit
);
    logic [ADDR_W-1:0] diff;

    // Purpose: equality over the granule bits only.
    always_comb begin
        diff = (link_addr ^ probe_addr) >> GRAIN_LSB;
        hit  = (diff == '0);
    end
endmodule

// File: rtl/link_state_reg.sv
// Module: holds the link flag and the linked word address.
// Assumes op is one event per cycle, and st_hit is valid whenever
// op is a store.
module link_state_reg
    import atomic_link_pkg::*;
#(
    parameter int ADDR_W = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  link_op_e          op,
    input  logic [ADDR_W-1:0] ll_addr,
    input  logic              st_hit,
    output logic              link_q,
    output logic [ADDR_W-1:0] addr_q
);
    // Purpose: update the link on each event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            link_q <= 1'b0;
            addr_q <= '0;
        end else begin
            case (op)
                LOP_LOAD: begin
                    link_q <= 1'b1;
                    addr_q <= ll_addr;
                end
                LOP_COND: link_q <= 1'b0;
                LOP_ERET: link_q <= 1'b0;
                LOP_STORE: if (st_hit) link_q <= 1'b0;
                default: ;
            endcase
        end
    end

    assert_load_arms_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op == LOP_LOAD) |=> (link_q && addr_q == $past(ll_addr)));
    assert_cond_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op == LOP_COND) |=> !link_q);
    assert_eret_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op == LOP_ERET) |=> !link_q);
    assert_store_hit_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op == LOP_STORE && st_hit) |=> !link_q);
    assert_store_miss_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op == LOP_STORE && !st_hit) |=> (link_q == $past(link_q)));
endmodule

// File: rtl/atomic_link_monitor.sv
// Module: top of the load-linked / store-conditional monitor.
// It grants a store-conditional in the same cycle when the link is armed
// and the address matches, and drives the 0/1 destination value.
// Assumes at most one event strobe per cycle and word addresses on all ports.
module atomic_link_monitor
    import atomic_link_pkg::*;
#(
    parameter int ADDR_W    = 30,
    parameter int XLEN      = 32,
    parameter int GRAIN_LSB = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ll_valid,
    input  logic [ADDR_W-1:0] ll_addr,
    input  logic              sc_valid,
    input  logic [ADDR_W-1:0] sc_addr,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic              eret_valid,
    output logic              sc_grant,
    output logic [XLEN-1:0]   sc_rd_value
);
    localparam int PAD_W = XLEN - 1;

    link_op_e          op;
    logic              link_q;
    logic [ADDR_W-1:0] addr_q;
    logic              sc_hit;
    logic              st_hit;

    link_op_decode u_dec (
        .ll_valid   (ll_valid),
        .sc_valid   (sc_valid),
        .st_valid   (st_valid),
        .eret_valid (eret_valid),
        .op         (op)
    );

    link_addr_match #(.ADDR_W(ADDR_W), .GRAIN_LSB(GRAIN_LSB)) u_sc_match (
        .link_addr  (addr_q),
        .probe_addr (sc_addr),
        .hit        (sc_hit)
    );

    link_addr_match #(.ADDR_W(ADDR_W), .GRAIN_LSB(GRAIN_LSB)) u_st_match (
        .link_addr  (addr_q),
        .probe_addr (st_addr),
        .hit        (st_hit)
    );

    link_state_reg #(.ADDR_W(ADDR_W)) u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (op),
        .ll_addr (ll_addr),
        .st_hit  (st_hit),
        .link_q  (link_q),
        .addr_q  (addr_q)
    );

    // Purpose: decide the grant and form the destination value.
    always_comb begin
        sc_grant    = (op == LOP_COND) && link_q && sc_hit;
        sc_rd_value = {{PAD_W{1'b0}}, sc_grant};
    end

    assert_single_event_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({ll_valid, sc_valid, st_valid, eret_valid}) <= 1);
    assert_grant_needs_link_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sc_grant |-> (sc_valid && link_q && sc_addr == addr_q));
    assert_grant_only_on_cond_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !sc_valid |-> !sc_grant);
endmodule

// File: tb/atomic_link_monitor_test.sv
`timescale 1ns/1ps
module atomic_link_monitor_test;
    localparam int AW = 30;
    localparam int XW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ll_valid = 1'b0, sc_valid = 1'b0, st_valid = 1'b0, eret_valid = 1'b0;
    logic [AW-1:0] ll_addr = '0, sc_addr = '0, st_addr = '0;
    logic          sc_grant;
    logic [XW-1:0] sc_rd_value;

    int checks = 0;
    int fails  = 0;
    bit m_link = 1'b0;
    logic [AW-1:0] m_addr = '0;

    always #2.5 clk = ~clk;

    atomic_link_monitor #(.ADDR_W(AW), .XLEN(XW)) uut (
        .clk(clk), .rst_n(rst_n),
        .ll_valid(ll_valid), .ll_addr(ll_addr),
        .sc_valid(sc_valid), .sc_addr(sc_addr),
        .st_valid(st_valid), .st_addr(st_addr),
        .eret_valid(eret_valid),
        .sc_grant(sc_grant), .sc_rd_value(sc_rd_value)
    );

    function automatic logic exp_grant(input bit lk, input logic [AW-1:0] la,
                                       input logic [AW-1:0] a);
        return lk && (la == a);
    endfunction

    function automatic logic [XW-1:0] exp_value(input logic g);
        return g ? XW'(1) : '0;
    endfunction

    task automatic check(input string req, input logic [XW-1:0] act, input logic [XW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // op: 0 idle, 1 load-linked, 2 store-conditional, 3 store, 4 eret
    task automatic do_op(input int op, input logic [AW-1:0] a, input string req);
        logic g;
        @(negedge clk);
        ll_valid = (op == 1); sc_valid = (op == 2);
        st_valid = (op == 3); eret_valid = (op == 4);
        ll_addr = a; sc_addr = a; st_addr = a;
        #1;
        if (op == 2) begin
            g = exp_grant(m_link, m_addr, a);
            check({req, " grant"}, XW'(sc_grant), XW'(g));
            check({req, " value"}, sc_rd_value, exp_value(g));
        end else begin
            check({req, " no grant"}, XW'(sc_grant), '0);
        end
        case (op)
            1: begin m_link = 1'b1; m_addr = a; end
            2: m_link = 1'b0;
            3: if (m_link && m_addr == a) m_link = 1'b0;
            4: m_link = 1'b0;
            default: ;
        endcase
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        do_op(2, 30'd5, "R1 sc after reset");
        do_op(1, 30'd5, "R2 ll");
        do_op(2, 30'd5, "R2 R3 matching sc");
        do_op(2, 30'd5, "R5 second sc");
        do_op(1, 30'd5, "R4 ll");
        do_op(2, 30'd6, "R4 other address");
        do_op(2, 30'd5, "R5 after refused sc R9");
        do_op(1, 30'd7, "R6 ll");
        do_op(3, 30'd8, "R6 store elsewhere");
        do_op(2, 30'd7, "R6 sc kept");
        do_op(1, 30'd7, "R6 ll");
        do_op(3, 30'd7, "R6 store linked");
        do_op(2, 30'd7, "R6 sc broken");
        do_op(1, 30'd9, "R7 ll");
        do_op(4, 30'd0, "R7 eret");
        do_op(2, 30'd9, "R7 sc after eret");
        do_op(1, 30'd1, "R8 ll");
        do_op(1, 30'd2, "R8 ll");
        do_op(2, 30'd1, "R8 older address");
        do_op(1, 30'd1, "R8 ll");
        do_op(1, 30'd2, "R8 ll");
        do_op(2, 30'd2, "R8 newer address");
        for (int i = 0; i < 3000; i++) begin
            do_op(int'($urandom % 5), AW'($urandom % 4), "R3 R10 random");
        end
        // reset mid-link: link must drop (R1)
        do_op(1, 30'd3, "R1 ll");
        @(negedge clk);
        ll_valid = 1'b0;
        rst_n = 1'b0;
        m_link = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        do_op(2, 30'd3, "R1 sc after reset");
        do_op(0, 30'd0, "R3 idle");
        finish_run();
    end
endmodule